// File: doc/BRIEF.md
# Configurable Block Motion Search Engine

This block finds the displacement of one luma block inside a reference search area. It scores each candidate displacement by the sum of absolute pixel differences (SAD) between the current block and the reference pixels under it. The lowest score wins. Three candidate orderings are available: an exhaustive raster sweep, a ring-by-ring sweep that starts at zero displacement, and a coarse-to-fine three-step search. The three-step search scores far fewer candidates and so draws less power, at some loss of match quality. The block edge is 16 or 8 pixels. The search range is a parameter.

Each job takes three streams. A short configuration word arrives first and picks the strategy and the block size for that job, so these can change from one frame to the next. The pixel stream follows and fills two local buffers, first the current block and then the reference area. When the last pixel is in, the search runs by itself. The result leaves on the output stream as a one-cycle strobe carrying a signed horizontal and vertical displacement and the winning cost.

Top module: `motsrch_top`

## Requirements
- R1: While reset is high and in the first cycle after it, out_valid is 0, cfg_ready is 1 and pix_ready is 0.
- R2: A job starts when a configuration word is taken (cfg_valid and cfg_ready). Bits [1:0] select the strategy: 0 exhaustive, 1 ring, 2 three-step, and 3 behaves exactly like 0. Bit 2 set selects an 8x8 block; bit 2 clear selects 16x16.
- R3: After the configuration word, the block takes N*N current-block pixels, then (N+2*RANGE)^2 reference pixels, each set in row-major order with the top row first. For candidate (dx,dy), current pixel (py,px) is compared with reference pixel (py+RANGE+dy, px+RANGE+dx). The reported cost is the SAD over all N*N pixels.
- R4: The exhaustive strategy scores every dx,dy in [-RANGE,RANGE]. dy is the outer loop and dx the inner loop, both counting up from -RANGE. The lowest cost wins, and on a tie the candidate scored earlier wins.
- R5: The ring strategy scores ring r = 0..RANGE, where r = max(|dx|,|dy|). Within a ring it uses the same row-major order as R4. On a tie the earlier candidate wins, so the nearer ring wins.
- R6: The three-step strategy starts with step S0 at center (0,0). S0 is the largest power of two with 2*S0-1 <= RANGE, which gives 4 for RANGE=7. Each step scores the 9 points center+(j*s, i*s) for i,j in {-1,0,1}, with i outer and j inner. The best point of that step, earliest on a tie, becomes the next center. The step then halves. The result is the best point of the step with s=1.
- R7: A result is one cycle of out_valid with out_mv_x and out_mv_y in two's complement and the cost in out_cost.
- R8: cfg_ready is high only between jobs, and pix_ready only while loading. Words offered on either stream during a search have no effect on the result.
- R9: out_valid rises exactly U*(N*N+4)+K+1 cycles after the clock edge that takes the last reference pixel. U is the number of candidates scored and K is the number of ring positions skipped because they lie inside the current ring. cfg_ready is high again in the cycle out_valid is high.
- R10: Cycles with pix_valid low during loading take no pixel and leave the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_valid | input | 1 | Configuration word offered |
| cfg_word | input | 3 | Strategy [1:0], small block flag [2] |
| cfg_ready | output | 1 | Block is between jobs and takes a configuration word |
| pix_valid | input | 1 | Pixel offered |
| pix_data | input | PIX_W (8) | Pixel value |
| pix_ready | output | 1 | Block is loading pixels |
| out_valid | output | 1 | One-cycle result strobe |
| out_mv_x | output | MV_W (5) | Signed horizontal displacement |
| out_mv_y | output | MV_W (5) | Signed vertical displacement |
| out_cost | output | COST_W (16) | Minimum SAD |

## Verification
The result comes a fixed, data-independent number of cycles after the last reference pixel is taken. That delay is U*(N*N+4)+K+1 cycles, and it depends only on the strategy and the block size. For each job, the driver works out the expected winner, the cost and that delay from a software sweep of the same candidate order. It records the cycle in which the last pixel was taken and queues both with the expected values. The monitor samples on falling edges. When out_valid appears, it checks the displacement, the cost and the elapsed cycle count against the queued entry, and it checks that the strobe is gone one cycle later.

// File: rtl/motsrch_pkg.sv
`timescale 1ns/1ps
package motsrch_pkg;

  typedef enum logic [1:0] {
    SRCH_FULL   = 2'd0,
    SRCH_RING   = 2'd1,
    SRCH_3STEP  = 2'd2,
    SRCH_ALIAS  = 2'd3
  } srch_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_CAND, ST_ACC, ST_DRAIN, ST_CMP, ST_NEXT, ST_OUT
  } srch_state_e;

  // coarsest step whose sum of halvings stays inside the range
  function automatic int first_step(input int range);
    int s;
    s = 1;
    for (int k = 0; k < 16; k++) begin
      if (4 * s - 1 <= range) s = 2 * s;
    end
    return s;
  endfunction

endpackage

// File: rtl/motsrch_gen.sv
`timescale 1ns/1ps
module motsrch_gen
  import motsrch_pkg::*;
#(
  parameter int RANGE = 7,
  parameter int MV_W  = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  srch_mode_e             mode,
  input  logic                   adv,
  input  logic signed [MV_W-1:0] best_dx,
  input  logic signed [MV_W-1:0] best_dy,
  output logic signed [MV_W-1:0] cand_dx,
  output logic signed [MV_W-1:0] cand_dy,
  output logic                   cand_use,
  output logic                   cand_first,
  output logic                   cand_last
);
  typedef logic signed [MV_W-1:0] mv_t;
  localparam mv_t RNG   = mv_t'(RANGE);
  localparam mv_t STEP0 = mv_t'(first_step(RANGE));
  localparam mv_t ONE   = mv_t'(1);

  mv_t gx, gy, lvl, cx, cy;

  function automatic mv_t mag(input mv_t v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic mv_t scale(input mv_t u, input mv_t s);
    if (u == 0) return '0;
    return (u < 0) ? -s : s;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      gx <= '0; gy <= '0; lvl <= '0; cx <= '0; cy <= '0;
    end else if (start) begin
      cx <= '0;
      cy <= '0;
      case (mode)
        SRCH_RING:  begin lvl <= '0;    gx <= '0;   gy <= '0;   end
        SRCH_3STEP: begin lvl <= STEP0; gx <= -ONE; gy <= -ONE; end
        default:    begin lvl <= '0;    gx <= -RNG; gy <= -RNG; end
      endcase
    end else if (adv) begin
      case (mode)
        SRCH_RING: begin
          if (gx == lvl) begin
            if (gy == lvl) begin
              lvl <= lvl + ONE;
              gx  <= -(lvl + ONE);
              gy  <= -(lvl + ONE);
            end else begin
              gx <= -lvl;
              gy <= gy + ONE;
            end
          end else begin
            gx <= gx + ONE;
          end
        end
        SRCH_3STEP: begin
          if (gx == ONE) begin
            gx <= -ONE;
            if (gy == ONE) begin
              gy  <= -ONE;
              lvl <= lvl >>> 1;
              cx  <= best_dx;
              cy  <= best_dy;
            end else begin
              gy <= gy + ONE;
            end
          end else begin
            gx <= gx + ONE;
          end
        end
        default: begin
          if (gx == RNG) begin
            gx <= -RNG;
            gy <= gy + ONE;
          end else begin
            gx <= gx + ONE;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (mode)
      SRCH_RING: begin
        cand_dx    = gx;
        cand_dy    = gy;
        cand_use   = (mag(gx) == lvl) || (mag(gy) == lvl);
        cand_first = (lvl == 0);
        cand_last  = (lvl == RNG) && (gx == RNG) && (gy == RNG);
      end
      SRCH_3STEP: begin
        cand_dx    = cx + scale(gx, lvl);
        cand_dy    = cy + scale(gy, lvl);
        cand_use   = 1'b1;
        cand_first = (gx == -ONE) && (gy == -ONE);
        cand_last  = (lvl == ONE) && (gx == ONE) && (gy == ONE);
      end
      default: begin
        cand_dx    = gx;
        cand_dy    = gy;
        cand_use   = 1'b1;
        cand_first = (gx == -RNG) && (gy == -RNG);
        cand_last  = (gx == RNG) && (gy == RNG);
      end
    endcase
  end

endmodule

// File: rtl/motsrch_sad.sv
`timescale 1ns/1ps
module motsrch_sad #(
  parameter int PIX_W  = 8,
  parameter int CUR_D  = 256,
  parameter int REF_D  = 900,
  parameter int CA_W   = 8,
  parameter int RA_W   = 10,
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cur_we,
  input  logic [CA_W-1:0]   cur_wa,
  input  logic              ref_we,
  input  logic [RA_W-1:0]   ref_wa,
  input  logic [PIX_W-1:0]  wd,
  input  logic              rd_en,
  input  logic [CA_W-1:0]   cur_ra,
  input  logic [RA_W-1:0]   ref_ra,
  input  logic              clr,
  output logic [COST_W-1:0] acc
);
  logic [PIX_W-1:0] cur_mem [CUR_D];
  logic [PIX_W-1:0] ref_mem [REF_D];
  logic [PIX_W-1:0] cur_q, ref_q, diff;
  logic             rd_vld;

  // one write and one registered read per buffer: maps onto block RAM
  always_ff @(posedge clk) begin
    if (cur_we) cur_mem[cur_wa] <= wd;
    cur_q <= cur_mem[cur_ra];
  end

  always_ff @(posedge clk) begin
    if (ref_we) ref_mem[ref_wa] <= wd;
    ref_q <= ref_mem[ref_ra];
  end

  always_comb diff = (cur_q > ref_q) ? (cur_q - ref_q) : (ref_q - cur_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld <= 1'b0;
      acc    <= '0;
    end else begin
      rd_vld <= rd_en;
      if (clr)         acc <= '0;
      else if (rd_vld) acc <= acc + COST_W'(diff);
    end
  end

endmodule

// File: rtl/motsrch_top.sv
`timescale 1ns/1ps
module motsrch_top
  import motsrch_pkg::*;
#(
  parameter  int PIX_W   = 8,
  parameter  int BLK_MAX = 16,
  parameter  int BLK_MIN = 8,
  parameter  int RANGE   = 7,
  localparam int MV_W    = $clog2(RANGE + 1) + 2,
  localparam int COST_W  = PIX_W + $clog2(BLK_MAX * BLK_MAX)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_valid,
  input  logic [2:0]               cfg_word,
  output logic                     cfg_ready,
  input  logic                     pix_valid,
  input  logic [PIX_W-1:0]         pix_data,
  output logic                     pix_ready,
  output logic                     out_valid,
  output logic signed [MV_W-1:0]   out_mv_x,
  output logic signed [MV_W-1:0]   out_mv_y,
  output logic [COST_W-1:0]        out_cost
);
  localparam int REFW  = BLK_MAX + 2 * RANGE;
  localparam int CUR_D = BLK_MAX * BLK_MAX;
  localparam int REF_D = REFW * REFW;
  localparam int CA_W  = $clog2(CUR_D);
  localparam int RA_W  = $clog2(REF_D);
  localparam int PC_W  = $clog2(BLK_MAX);
  localparam int LC_W  = $clog2(REFW + 1);

  srch_state_e state;
  srch_mode_e  mode_q;
  logic        small_q;
  int          blk_n, ld_lim;

  logic [LC_W-1:0] ld_row, ld_col;
  logic            ld_ref;
  logic [PC_W-1:0] py, px;

  logic signed [MV_W-1:0] cand_dx, cand_dy, best_dx, best_dy;
  logic                   cand_use, cand_first, cand_last;
  logic [COST_W-1:0]      acc, best_cost;

  logic pix_fire, ld_row_end, ld_col_end, gen_start, gen_adv;
  logic [CA_W-1:0] cur_wa, cur_ra;
  logic [RA_W-1:0] ref_wa, ref_ra;

  assign cfg_ready = (state == ST_IDLE);
  assign pix_ready = (state == ST_LOAD);

  always_comb begin
    blk_n      = small_q ? BLK_MIN : BLK_MAX;
    ld_lim     = ld_ref ? (blk_n + 2 * RANGE) : blk_n;
    pix_fire   = pix_valid && (state == ST_LOAD);
    ld_row_end = (int'(ld_row) == ld_lim - 1);
    ld_col_end = (int'(ld_col) == ld_lim - 1);
    gen_start  = pix_fire && ld_ref && ld_row_end && ld_col_end;
    gen_adv    = ((state == ST_CAND) && !cand_use) ||
                 ((state == ST_NEXT) && !cand_last);
    cur_wa     = CA_W'(int'(ld_row) * BLK_MAX + int'(ld_col));
    ref_wa     = RA_W'(int'(ld_row) * REFW + int'(ld_col));
    cur_ra     = CA_W'(int'(py) * BLK_MAX + int'(px));
    ref_ra     = RA_W'((int'(cand_dy) + RANGE + int'(py)) * REFW
                       + int'(cand_dx) + RANGE + int'(px));
  end

  motsrch_gen #(.RANGE(RANGE), .MV_W(MV_W)) u_gen (
    .clk(clk), .rst(rst), .start(gen_start), .mode(mode_q), .adv(gen_adv),
    .best_dx(best_dx), .best_dy(best_dy),
    .cand_dx(cand_dx), .cand_dy(cand_dy), .cand_use(cand_use),
    .cand_first(cand_first), .cand_last(cand_last)
  );

  motsrch_sad #(
    .PIX_W(PIX_W), .CUR_D(CUR_D), .REF_D(REF_D),
    .CA_W(CA_W), .RA_W(RA_W), .COST_W(COST_W)
  ) u_sad (
    .clk(clk), .rst(rst),
    .cur_we(pix_fire && !ld_ref), .cur_wa(cur_wa),
    .ref_we(pix_fire && ld_ref),  .ref_wa(ref_wa),
    .wd(pix_data), .rd_en(state == ST_ACC),
    .cur_ra(cur_ra), .ref_ra(ref_ra),
    .clr(state == ST_CAND), .acc(acc)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mode_q    <= SRCH_FULL;
      small_q   <= 1'b0;
      ld_row    <= '0;
      ld_col    <= '0;
      ld_ref    <= 1'b0;
      py        <= '0;
      px        <= '0;
      best_dx   <= '0;
      best_dy   <= '0;
      best_cost <= '0;
      out_valid <= 1'b0;
      out_mv_x  <= '0;
      out_mv_y  <= '0;
      out_cost  <= '0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        ST_IDLE: if (cfg_valid) begin
          mode_q  <= srch_mode_e'(cfg_word[1:0]);
          small_q <= cfg_word[2];
          ld_row  <= '0;
          ld_col  <= '0;
          ld_ref  <= 1'b0;
          state   <= ST_LOAD;
        end
        ST_LOAD: if (pix_fire) begin
          if (ld_col_end) begin
            ld_col <= '0;
            if (ld_row_end) begin
              ld_row <= '0;
              ld_ref <= 1'b1;
              if (ld_ref) state <= ST_CAND;
            end else begin
              ld_row <= ld_row + LC_W'(1);
            end
          end else begin
            ld_col <= ld_col + LC_W'(1);
          end
        end
        ST_CAND: if (cand_use) begin
          py    <= '0;
          px    <= '0;
          state <= ST_ACC;
        end
        ST_ACC: begin
          if (int'(px) == blk_n - 1) begin
            px <= '0;
            if (int'(py) == blk_n - 1) state <= ST_DRAIN;
            else py <= py + PC_W'(1);
          end else begin
            px <= px + PC_W'(1);
          end
        end
        ST_DRAIN: state <= ST_CMP;
        ST_CMP: begin
          if (cand_first || (acc < best_cost)) begin
            best_cost <= acc;
            best_dx   <= cand_dx;
            best_dy   <= cand_dy;
          end
          state <= ST_NEXT;
        end
        ST_NEXT: state <= cand_last ? ST_OUT : ST_CAND;
        ST_OUT: begin
          out_valid <= 1'b1;
          out_mv_x  <= best_dx;
          out_mv_y  <= best_dy;
          out_cost  <= best_cost;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/motsrch_chk.sv
`timescale 1ns/1ps
module motsrch_chk #(
  parameter int RANGE  = 7,
  parameter int MV_W   = 5,
  parameter int COST_W = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cfg_valid,
  input logic                   cfg_ready,
  input logic                   pix_ready,
  input logic                   out_valid,
  input logic signed [MV_W-1:0] out_mv_x,
  input logic signed [MV_W-1:0] out_mv_y,
  input logic [COST_W-1:0]      out_cost
);
  // R7: the result strobe lasts a single cycle
  a_r7_one_cycle: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  // R7: reported displacement lies inside the search range
  a_r7_in_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_mv_x >= -RANGE) && (out_mv_x <= RANGE) &&
                  (out_mv_y >= -RANGE) && (out_mv_y <= RANGE));

  // R8: configuration and pixel streams are never open together
  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(cfg_ready && pix_ready));

  // R2: a taken configuration word opens the pixel stream
  a_r2_load_follows: assert property (@(posedge clk) disable iff (rst)
    (cfg_valid && cfg_ready) |=> pix_ready);

  // R9: the block is ready for the next job as the result appears
  a_r9_ready_with_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> cfg_ready && !pix_ready);

  // R7: the cost output holds between results
  a_r7_cost_held: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(out_valid) && !$past(rst)) |-> $stable(out_cost));

endmodule

bind motsrch_top motsrch_chk #(.RANGE(RANGE), .MV_W(MV_W), .COST_W(COST_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
  .pix_ready(pix_ready), .out_valid(out_valid), .out_mv_x(out_mv_x),
  .out_mv_y(out_mv_y), .out_cost(out_cost)
);

// File: tb/motsrch_top_tb_top.sv
`timescale 1ns/1ps
module motsrch_top_tb_top;
  localparam int R    = 7;
  localparam int BMAX = 16;
  localparam int WMAX = BMAX + 2 * R;
  localparam int S0   = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic cfg_valid = 1'b0;
  logic [2:0] cfg_word = '0;
  logic cfg_ready, pix_ready, out_valid;
  logic pix_valid = 1'b0;
  logic [7:0] pix_data = '0;
  logic signed [4:0] out_mv_x, out_mv_y;
  logic [15:0] out_cost;

  always #2.5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  motsrch_top dut_i (
    .clk(clk), .rst(rst), .cfg_valid(cfg_valid), .cfg_word(cfg_word),
    .cfg_ready(cfg_ready), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .out_valid(out_valid), .out_mv_x(out_mv_x),
    .out_mv_y(out_mv_y), .out_cost(out_cost)
  );

  int tests = 0, fails = 0;
  int cur_px [BMAX][BMAX];
  int ref_px [WMAX][WMAX];

  typedef struct {
    int dx; int dy; int cost; int a; int lat; string tag;
  } exp_t;
  exp_t sb[$];
  exp_t mon_e;
  bit   prev_ov = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sad_at(input int n, input int dx, input int dy);
    int s = 0;
    for (int y = 0; y < n; y++)
      for (int x = 0; x < n; x++)
        s += iabs(cur_px[y][x] - ref_px[y + R + dy][x + R + dx]);
    return s;
  endfunction

  // kind 0: random reference, block copied from a displaced spot with noise
  // kind 1: flat fields so every candidate costs the same
  task automatic fill(input int kind, input int pdx, input int pdy);
    for (int y = 0; y < WMAX; y++)
      for (int x = 0; x < WMAX; x++)
        ref_px[y][x] = (kind == 1) ? 13 : int'($urandom_range(0, 255));
    for (int y = 0; y < BMAX; y++)
      for (int x = 0; x < BMAX; x++)
        cur_px[y][x] = (kind == 1) ? 10 :
                       (ref_px[y + R + pdy][x + R + pdx] ^ int'($urandom_range(0, 3)));
  endtask

  task automatic model(input int n, input int mode, output int bdx, output int bdy,
                       output int bc, output int u, output int k);
    int c;
    u = 0; k = 0; bdx = 0; bdy = 0; bc = 0;
    if (mode == 2) begin
      int cx = 0, cy = 0;
      for (int s = S0; s >= 1; s = s / 2) begin
        bit first = 1'b1;
        for (int i = -1; i <= 1; i++)
          for (int j = -1; j <= 1; j++) begin
            c = sad_at(n, cx + j * s, cy + i * s);
            u++;
            if (first || c < bc) begin bc = c; bdx = cx + j * s; bdy = cy + i * s; end
            first = 1'b0;
          end
        cx = bdx; cy = bdy;
      end
    end else if (mode == 1) begin
      for (int r = 0; r <= R; r++)
        for (int dy = -r; dy <= r; dy++)
          for (int dx = -r; dx <= r; dx++) begin
            if (iabs(dx) == r || iabs(dy) == r) begin
              c = sad_at(n, dx, dy);
              if (u == 0 || c < bc) begin bc = c; bdx = dx; bdy = dy; end
              u++;
            end else k++;
          end
    end else begin
      for (int dy = -R; dy <= R; dy++)
        for (int dx = -R; dx <= R; dx++) begin
          c = sad_at(n, dx, dy);
          if (u == 0 || c < bc) begin bc = c; bdx = dx; bdy = dy; end
          u++;
        end
    end
  endtask

  task automatic send_cfg(input logic [2:0] w);
    @(negedge clk);
    cfg_valid = 1'b1; cfg_word = w;
    while (!cfg_ready) @(negedge clk);
    @(posedge clk); #1;
    cfg_valid = 1'b0;
  endtask

  task automatic send_pix(input int v, input bit gaps);
    if (gaps) repeat ($urandom_range(0, 2)) @(negedge clk);
    @(negedge clk);
    pix_valid = 1'b1; pix_data = 8'(v);
    while (!pix_ready) @(negedge clk);
    @(posedge clk); #1;
    pix_valid = 1'b0;
  endtask

  task automatic run_job(input logic [2:0] w, input int kind, input int pdx,
                         input int pdy, input bit gaps, input bit junk,
                         input string tag);
    exp_t e;
    int n, bdx, bdy, bc, u, k, bad;
    n = w[2] ? 8 : 16;
    fill(kind, pdx, pdy);
    model(n, int'(w[1:0]), bdx, bdy, bc, u, k);
    send_cfg(w);
    for (int y = 0; y < n; y++)
      for (int x = 0; x < n; x++) send_pix(cur_px[y][x], gaps);
    for (int y = 0; y < n + 2 * R; y++)
      for (int x = 0; x < n + 2 * R; x++) send_pix(ref_px[y][x], gaps);
    e.dx = bdx; e.dy = bdy; e.cost = bc; e.a = cyc;
    e.lat = u * (n * n + 4) + k + 1; e.tag = tag;
    sb.push_back(e);
    if (junk) begin
      bad = 0;
      @(negedge clk);
      cfg_valid = 1'b1; cfg_word = ~w; pix_valid = 1'b1; pix_data = 8'hAA;
      for (int i = 0; i < 40; i++) begin
        @(negedge clk);
        if (cfg_ready || pix_ready) bad++;
      end
      cfg_valid = 1'b0; pix_valid = 1'b0;
      check(bad == 0, "R8", "ready seen during search", bad, 0);
    end
    while (sb.size() != 0) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (prev_ov) check(!out_valid, "R7", "strobe longer than one cycle", int'(out_valid), 0);
    prev_ov <= out_valid && !rst;
    if (!rst && out_valid) begin
      if (sb.size() == 0) check(1'b0, "R7", "result with nothing expected", 1, 0);
      else begin
        mon_e = sb.pop_front();
        check(int'(out_mv_x) == mon_e.dx, mon_e.tag, "mv_x", int'(out_mv_x), mon_e.dx);
        check(int'(out_mv_y) == mon_e.dy, mon_e.tag, "mv_y", int'(out_mv_y), mon_e.dy);
        check(int'(out_cost) == mon_e.cost, mon_e.tag, "cost", int'(out_cost), mon_e.cost);
        check(cyc - mon_e.a == mon_e.lat, "R9", "latency", cyc - mon_e.a, mon_e.lat);
        check(cfg_ready == 1'b1, "R9", "cfg_ready with result", int'(cfg_ready), 1);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R9", "watchdog expired", cyc, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    check(cfg_ready == 1'b1, "R1", "cfg_ready in reset", int'(cfg_ready), 1);
    check(pix_ready == 1'b0, "R1", "pix_ready in reset", int'(pix_ready), 0);
    rst = 1'b0;
    @(negedge clk);
    check(cfg_ready == 1'b1 && pix_ready == 1'b0, "R1", "ready after reset",
          int'({cfg_ready, pix_ready}), 2);

    run_job(3'b100,  0,  2, -3, 1'b0, 1'b0, "R3");   // 8x8 exhaustive, random
    run_job(3'b100,  1,  0,  0, 1'b0, 1'b0, "R4");   // exhaustive ties -> (-7,-7)
    run_job(3'b101,  1,  0,  0, 1'b0, 1'b0, "R5");   // ring ties -> (0,0)
    run_job(3'b010,  0, -5,  3, 1'b0, 1'b0, "R6");   // 16x16 three-step, random
    run_job(3'b010,  1,  0,  0, 1'b1, 1'b1, "R10");  // three-step ties, idle gaps, junk
    run_job(3'b111,  0, -7,  7, 1'b0, 1'b0, "R2");   // code 3 acts as exhaustive
    run_job(3'b101,  0,  1,  1, 1'b0, 1'b1, "R8");   // ring, junk during search
    run_job(3'b110,  0,  3, -2, 1'b0, 1'b0, "R6");   // 8x8 three-step

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule